// File: doc/BRIEF.md
# Two-wire dual wiper register slave

This block is a serial slave on a two-wire bus with clock and data lines. It holds the 8-bit wiper codes for two potentiometer channels and drives them out as tap selects. The data line is open-drain: the block only pulls it low, and the bus pull-up supplies the high level. The clock line and the data line are synchronized into the block clock domain. START and STOP conditions and clock edges are then recovered from them.

A transaction opens with an address byte. An instruction byte follows it and picks one channel. When the write flag in that byte is set, a single data byte follows and replaces the selected wiper code in one step. A read starts with a pointer-setting dummy write made of the address byte and the instruction byte. The master then issues a repeated START and the address byte with the read flag set. The block acknowledges it and shifts out the selected code, most significant bit first. Reserved channel codes, a foreign address and a malformed instruction all make the block fall silent until the next START.

Top module: `wiper_slave`

## Requirements
- R1: After reset, both wiper outputs are 00h and the data line is not pulled low.
- R2: The address byte is matched MSB first with bits 7:4 = 1010, bit 3 = the level of addr_pin_i, bits 2:1 = 11, and bit 0 = R/W (0 write, 1 read). A match is acknowledged. On a mismatch the block does not acknowledge and ignores the bus until the next START, so later bytes neither get an ACK nor change a wiper.
- R3: The instruction byte has bits 7:4 = 0000, bit 3 = write flag, bit 2 = don't care, and bits 1:0 = channel code: 01 selects channel 1 and 10 selects channel 2. A valid instruction byte is acknowledged, whatever the value of bit 2.
- R4: An instruction byte with channel code 00 or 11, or with any of bits 7:4 set, is not acknowledged. The data byte that follows gets no ACK and changes neither wiper.
- R5: When the write flag is 1, the next data byte is acknowledged and replaces all 8 bits of the selected wiper at once. The other wiper keeps its value.
- R6: When the write flag is 0, the instruction only sets the read pointer. A following data byte is not acknowledged and changes no wiper.
- R7: After a valid instruction byte, a repeated START and an address byte with R/W = 1 are acknowledged. The block then shifts out the selected wiper code MSB first, whatever the write flag was, and the read leaves both wipers unchanged.
- R8: A STOP at any point returns the block to idle with the data line released and both wipers unchanged. The next transaction is then served normally.
- R9: The block changes its drive of the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversampling the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| addr_pin_i | input | 1 | Strapped address bit compared with address bit 3 |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wiper1_o | output | 8 | Wiper code of channel 1 |
| wiper2_o | output | 8 | Wiper code of channel 2 |

## Verification
A vector table drives write transactions through every instruction form: both valid channel codes, the don't-care bit set, both reserved codes, a non-zero upper nibble and a clear write flag. Together these separate a wrong channel decode from a missing ACK and from a write that should have been dropped. The data values change many bits at once, which exposes a partial register update. Directed sequences cover an address with the wrong strap bit, reads of both channels with the write flag either clear or set, and a STOP in the middle of a data byte followed by a clean write.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int unsigned WIPER_W = 8;
  localparam int unsigned NUM_CH  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_IGN
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INSTR, PH_DATA, PH_END
  } byte_ph_e;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;   // idle bus is high
      else         ff_q <= {ff_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/wiper_regs.sv
module wiper_regs #(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2,
  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [SW-1:0]  sel_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [NCH*W-1:0] q_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           r_q <= '0;
      else if (we_i && sel_i == SW'(c))      r_q <= wdata_i;
    end
    assign q_o[c*W +: W] = r_q;
  end

  assign rdata_o = q_o[sel_i*W +: W];
endmodule

// File: rtl/wiper_bus_eng.sv
module wiper_bus_eng
  import wiper_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010,
  parameter logic [1:0]  ADDR_SUFFIX = 2'b11,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic         strap_i,
  input  logic [W-1:0] rd_data_i,
  output logic         sda_oe_o,
  output logic         we_o,
  output logic         sel_o,
  output logic [W-1:0] wdata_o,
  output logic         idle_o
);
  bus_st_e     state_q;
  byte_ph_e    phase_q;
  logic [W-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic full_q, oe_q, wt_q, ptr_q, go_tx_q, scl_d, sda_d;

  logic scl_rise, scl_fall, start_c, stop_c, addr_ok, instr_ok;
  assign scl_rise = scl_i & ~scl_d;
  assign scl_fall = ~scl_i & scl_d;
  assign start_c  = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_c   = scl_i & scl_d & ~sda_d & sda_i;
  assign addr_ok  = sh_q[7:1] == {DEV_TYPE, strap_i, ADDR_SUFFIX};
  assign instr_ok = (sh_q[7:4] == 4'b0000) && (sh_q[1] ^ sh_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; phase_q <= PH_ADDR; sh_q <= '0; cnt_q <= '0;
      full_q <= 1'b0; oe_q <= 1'b0; wt_q <= 1'b0; ptr_q <= 1'b0;
      go_tx_q <= 1'b0; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (start_c) begin
        state_q <= ST_RX; phase_q <= PH_ADDR; cnt_q <= '0;
        full_q <= 1'b0; oe_q <= 1'b0; go_tx_q <= 1'b0;
      end else if (stop_c) begin
        state_q <= ST_IDLE; oe_q <= 1'b0; full_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[W-2:0], sda_i};
              cnt_q <= cnt_q + CW'(1);
              if (cnt_q == CW'(W-1)) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_IGN;
              case (phase_q)
                PH_ADDR: if (addr_ok) begin
                  oe_q <= 1'b1; state_q <= ST_ACK;
                  go_tx_q <= sh_q[0]; phase_q <= PH_INSTR;
                end
                PH_INSTR: if (instr_ok) begin
                  oe_q <= 1'b1; state_q <= ST_ACK;
                  ptr_q <= sh_q[1]; wt_q <= sh_q[3]; phase_q <= PH_DATA;
                end
                PH_DATA: if (wt_q) begin
                  oe_q <= 1'b1; state_q <= ST_ACK; phase_q <= PH_END;
                end
                default: ;
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            oe_q <= 1'b0;
            if (go_tx_q) begin
              state_q <= ST_TX; sh_q <= rd_data_i; cnt_q <= '0;
              oe_q <= ~rd_data_i[W-1];
            end else if (phase_q == PH_END) begin
              state_q <= ST_IGN;
            end else begin
              state_q <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt_q == CW'(W-1)) begin
              oe_q <= 1'b0; state_q <= ST_IGN;
            end else begin
              sh_q  <= {sh_q[W-2:0], 1'b0};
              oe_q  <= ~sh_q[W-2];
              cnt_q <= cnt_q + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // load strobe coincides with the data-byte ACK decision
  assign we_o     = (state_q == ST_RX) && scl_fall && full_q && !start_c && !stop_c
                    && (phase_q == PH_DATA) && wt_q;
  assign wdata_o  = sh_q;
  assign sel_o    = ptr_q;
  assign sda_oe_o = oe_q;
  assign idle_o   = (state_q == ST_IDLE);
endmodule

// File: rtl/wiper_slave.sv
module wiper_slave
  import wiper_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_pin_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic [WIPER_W-1:0] wiper2_o
);
  logic scl_s, sda_s, we, sel, bus_idle;
  logic [WIPER_W-1:0] wdata, rdata;
  logic [NUM_CH*WIPER_W-1:0] wipers;

  wiper_sync #(.N(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({scl_i, sda_i}),
    .q_o ({scl_s, sda_s})
  );

  wiper_bus_eng #(.W(WIPER_W)) u_eng (
    .clk_i, .rst_ni,
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .strap_i   (addr_pin_i),
    .rd_data_i (rdata),
    .sda_oe_o,
    .we_o      (we),
    .sel_o     (sel),
    .wdata_o   (wdata),
    .idle_o    (bus_idle)
  );

  wiper_regs #(.W(WIPER_W), .NCH(NUM_CH)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (we),
    .sel_i   (sel),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .q_o     (wipers)
  );

  assign wiper1_o = wipers[0 +: WIPER_W];
  assign wiper2_o = wipers[WIPER_W +: WIPER_W];
endmodule

// File: rtl/wiper_slave_chk.sv
module wiper_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       bus_idle,
  input logic       sda_oe_o,
  input logic [7:0] wiper1_o,
  input logic [7:0] wiper2_o
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_ZERO: assert (wiper1_o == 8'h00 && wiper2_o == 8'h00 && !sda_oe_o); // R1

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s); // R9
  AST_W1_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper1_o) |-> sda_oe_o); // R5
  AST_W2_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper2_o) |-> sda_oe_o); // R5
  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(wiper1_o) || $stable(wiper2_o)); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle |-> !sda_oe_o); // R8
endmodule

bind wiper_slave wiper_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .bus_idle (bus_idle),
  .sda_oe_o (sda_oe_o),
  .wiper1_o (wiper1_o),
  .wiper2_o (wiper2_o)
);

// File: tb/wiper_slave_tb.sv
module wiper_slave_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o;
  logic [7:0] wiper1_o, wiper2_o;
  wire  sda_bus = sda_m & ~sda_oe_o;

  int n_chk = 0, n_bad = 0, r9_viol = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wiper_slave u_dut (
    .clk_i, .rst_ni,
    .scl_i (scl_m),
    .sda_i (sda_bus),
    .addr_pin_i (1'b1),
    .sda_oe_o, .wiper1_o, .wiper2_o
  );

  localparam logic [7:0] AW = 8'hAE, AR = 8'hAF;

  // {instr, data, exp_instr_ack, exp_data_ack, exp_w1, exp_w2}
  localparam logic [33:0] VEC [9] = '{
    {8'h09, 8'hA5, 1'b1, 1'b1, 8'hA5, 8'h00},  // R5 ch1
    {8'h0A, 8'h3C, 1'b1, 1'b1, 8'hA5, 8'h3C},  // R5 ch2
    {8'h0D, 8'h5A, 1'b1, 1'b1, 8'h5A, 8'h3C},  // R3 bit2 don't care
    {8'h08, 8'hFF, 1'b0, 1'b0, 8'h5A, 8'h3C},  // R4 code 00
    {8'h0B, 8'hFF, 1'b0, 1'b0, 8'h5A, 8'h3C},  // R4 code 11
    {8'h01, 8'hFF, 1'b1, 1'b0, 8'h5A, 8'h3C},  // R6 write flag clear
    {8'h19, 8'hFF, 1'b0, 1'b0, 8'h5A, 8'h3C},  // R4 upper nibble
    {8'h0A, 8'hFF, 1'b1, 1'b1, 8'h5A, 8'hFF},  // R5
    {8'h09, 8'h00, 1'b1, 1'b1, 8'h00, 8'hFF}   // R5
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(10); scl_m = 1'b1; cyc(10);
    sda_m = 1'b0; cyc(10); scl_m = 1'b0; cyc(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(10); scl_m = 1'b1; cyc(10);
    sda_m = 1'b1; cyc(20);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; cyc(10); scl_m = 1'b1; cyc(20); scl_m = 1'b0; cyc(10);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; cyc(10); scl_m = 1'b1; cyc(10);
    ack = ~sda_bus;
    cyc(10); scl_m = 1'b0; cyc(10);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(10); scl_m = 1'b1; cyc(10); b[i] = sda_bus; cyc(10); scl_m = 1'b0;
    end
    cyc(10); scl_m = 1'b1; cyc(20); scl_m = 1'b0; cyc(10);  // master NACK
  endtask

  task automatic do_read(input logic [7:0] instr, output logic [7:0] val,
                         output logic a_ack, output logic i_ack, output logic r_ack);
    bus_start(); send_byte(AW, a_ack); send_byte(instr, i_ack);
    bus_start(); send_byte(AR, r_ack); recv_byte(val); bus_stop();
  endtask

  // R9: drive of the data line only changes while the bus clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && sda_oe_o != oe_prev && scl_m) r9_viol++;
    oe_prev <= sda_oe_o;
  end

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_i);
      if (done) disable watchdog;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a, ia, da, ra;
    logic [7:0] v;
    cyc(5);
    chk("R1 wiper1 reset", wiper1_o, 8'h00);
    chk("R1 wiper2 reset", wiper2_o, 8'h00);
    chk("R1 sda released", sda_oe_o, 0);
    rst_ni = 1'b1; cyc(10);

    for (int k = 0; k < 9; k++) begin
      bus_start();
      send_byte(AW, a);
      send_byte(VEC[k][33:26], ia);
      send_byte(VEC[k][25:18], da);
      bus_stop();
      chk($sformatf("R2 vec%0d addr ack", k), a, 1);
      chk($sformatf("R3/R4 vec%0d instr ack", k), ia, VEC[k][17]);
      chk($sformatf("R5/R6 vec%0d data ack", k), da, VEC[k][16]);
      chk($sformatf("R5 vec%0d wiper1", k), wiper1_o, VEC[k][15:8]);
      chk($sformatf("R5 vec%0d wiper2", k), wiper2_o, VEC[k][7:0]);
    end

    // R2 strap mismatch: later bytes ignored
    bus_start(); send_byte(8'hA6, a); send_byte(8'h09, ia); send_byte(8'h77, da); bus_stop();
    chk("R2 strap mismatch no ack", a, 0);
    chk("R2 ignored instr", ia, 0);
    chk("R2 ignored data", da, 0);
    chk("R2 wiper1 kept", wiper1_o, 8'h00);
    // R2 wrong device type
    bus_start(); send_byte(8'hBE, a); bus_stop();
    chk("R2 device type mismatch", a, 0);

    // R7 read ch2 with write flag clear
    do_read(8'h02, v, a, ia, ra);
    chk("R7 read ch2 instr ack", ia, 1);
    chk("R7 read addr ack", ra, 1);
    chk("R7 read ch2 value", v, 8'hFF);
    // R7 read ch1 with write flag set
    bus_start(); send_byte(AW, a); send_byte(8'h09, ia); send_byte(8'hC3, da); bus_stop();
    do_read(8'h09, v, a, ia, ra);
    chk("R7 read ch1 value", v, 8'hC3);
    chk("R7 wiper1 unchanged", wiper1_o, 8'hC3);
    chk("R7 wiper2 unchanged", wiper2_o, 8'hFF);

    // R8 STOP in mid data byte
    bus_start(); send_byte(AW, a); send_byte(8'h0A, ia); send_bits(8'h12, 4); bus_stop();
    chk("R8 wiper2 kept after stop", wiper2_o, 8'hFF);
    chk("R8 sda released", sda_oe_o, 0);
    bus_start(); send_byte(AW, a); send_byte(8'h0A, ia); send_byte(8'h81, da); bus_stop();
    chk("R8 next write ack", da, 1);
    chk("R8 next write value", wiper2_o, 8'h81);

    chk("R9 drive changes with clock high", r9_viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule